// File: doc/BRIEF.md
# Audio Subframe Word Assembler

This block turns one stereo audio frame into two 32-slot subframe words for a two-channel serial digital audio link. When the frame strobe is high on a clock edge, the block captures both channels' samples, aux nibbles and validity, user and channel-status bits. On the next cycle it presents the channel-A (left) word. On the cycle after that it presents the channel-B (right) word. Each word comes with a preamble-kind tag, so a later line coder can insert the correct sync pattern.

Slot n of the output word is bit n of `sf_word`, and slot 0 is sent first. The preamble slots are left as zeros for the line coder to replace. The aux nibble, the sample, the three per-channel status bits and a parity bit fill the remaining slots. Line coding, the sync waveforms and channel-status block storage are handled outside this block.

Top module: `sfa_subframe_asm`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sf_valid` is 0, `sf_word` is 0, `sf_kind` is 2'b00 and `sf_chan_b` is 0.
- R2: A strobe accepted on edge k makes `sf_valid`=1 with `sf_chan_b`=0 after edge k, then `sf_valid`=1 with `sf_chan_b`=1 after edge k+1. After that, `sf_valid` returns to 0 unless another strobe is accepted.
- R3: Slots 0 to 3 of every word are 0.
- R4: Slots 4 to 7 carry the channel's aux nibble, with its LSB in slot 4.
- R5: The sample occupies slots 28-SMP_W up to 27, LSB first, with its MSB in slot 27. Slots 8 to 27-SMP_W are 0.
- R6: Slot 28 holds the validity bit, slot 29 the user bit and slot 30 the channel-status bit of that channel.
- R7: Slot 31 is set so that the number of ones across slots 4 to 31 is even.
- R8: The A word carries the left-channel inputs and the B word carries the right-channel inputs, both as sampled on the accepting strobe edge. Right inputs that change after that edge have no effect on the B word.
- R9: `sf_kind` is 2'b11 for an A word whose frame was strobed with `blk_start`=1, 2'b01 for any other A word, 2'b10 for every B word, and 2'b00 when `sf_valid` is 0.
- R10: A strobe sampled on the edge that ends the A-word cycle is ignored: the B word still follows, and then `sf_valid` drops.
- R11: A strobe sampled on the edge that ends the B-word cycle is accepted, so frames can run back to back every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Frame strobe; captures all channel inputs |
| blk_start | input | 1 | Frame begins a channel-status block |
| left_smp | input | SMP_W | Left (A) audio sample |
| right_smp | input | SMP_W | Right (B) audio sample |
| left_aux | input | 4 | Left aux nibble |
| right_aux | input | 4 | Right aux nibble |
| left_v | input | 1 | Left validity bit |
| right_v | input | 1 | Right validity bit |
| left_u | input | 1 | Left user bit |
| right_u | input | 1 | Right user bit |
| left_c | input | 1 | Left channel-status bit |
| right_c | input | 1 | Right channel-status bit |
| sf_valid | output | 1 | Output word valid |
| sf_word | output | 32 | Subframe word, slot n in bit n |
| sf_kind | output | 2 | Preamble kind tag |
| sf_chan_b | output | 1 | 1 for a B word, 0 for an A word |

## Verification
A wrong sequencing state shows up on the very next cycle. Possible symptoms are a missing or duplicated B word, a B word tagged as A, or a strobe that is dropped or accepted at the wrong phase. Back-to-back and mid-A strobes expose these within two cycles.

A stale or uncleared right-channel capture register only shows up in the B word. The bench therefore changes the right inputs right after each strobe. A slot-placement or parity fault shows up in the first word affected. Sweeps over every aux value, every V/U/C combination and a walking one through each sample bit reach every slot.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int SLOT_CNT  = 32;
    localparam int AUX_LO    = 4;
    localparam int AUD_LO    = 8;
    localparam int AUD_MSB   = 27;
    localparam int V_SLOT    = 28;
    localparam int U_SLOT    = 29;
    localparam int C_SLOT    = 30;
    localparam int P_SLOT    = 31;
    localparam int SMP_MAX_W = AUD_MSB - AUD_LO + 1;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'b00,
        KIND_A    = 2'b01,
        KIND_B    = 2'b10,
        KIND_BLK  = 2'b11
    } sf_kind_e;

    typedef struct packed {
        logic [3:0]           aux;
        logic [SMP_MAX_W-1:0] smp;
        logic                 v;
        logic                 u;
        logic                 c;
    } chan_fields_t;

    function automatic logic even_fill(input logic [SLOT_CNT-1:0] w);
        return ^w[C_SLOT:AUX_LO];
    endfunction

endpackage

// File: rtl/sfa_word_pack.sv
module sfa_word_pack
    import sfa_pkg::*;
#(
    parameter int SMP_W = 20
) (
    input  chan_fields_t         fields,
    output logic [SLOT_CNT-1:0]  word
);
    localparam int SMP_LO = AUD_MSB + 1 - SMP_W;

    logic [SLOT_CNT-1:0] body;

    always_comb begin
        body = '0;
        body[AUX_LO +: 4] = fields.aux;
        for (int i = 0; i < SMP_W; i++) begin
            body[SMP_LO + i] = fields.smp[i];
        end
        body[V_SLOT] = fields.v;
        body[U_SLOT] = fields.u;
        body[C_SLOT] = fields.c;
        word = body;
        word[P_SLOT] = even_fill(body);
    end

endmodule

// File: rtl/sfa_frame_ctrl.sv
module sfa_frame_ctrl
    import sfa_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_stb,
    input  logic         blk_start,
    input  chan_fields_t right_in,
    output logic         load_a,
    output logic         load_b,
    output logic         blk_now,
    output chan_fields_t right_held
);
    typedef enum logic {PH_FREE, PH_A_OUT} phase_e;

    phase_e phase_q;

    assign load_a  = frame_stb && (phase_q == PH_FREE);
    assign load_b  = (phase_q == PH_A_OUT);
    assign blk_now = blk_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_FREE;
            right_held <= '0;
        end else begin
            phase_q <= load_a ? PH_A_OUT : PH_FREE;
            if (load_a) begin
                right_held <= right_in;
            end
        end
    end

endmodule

// File: rtl/sfa_subframe_asm.sv
module sfa_subframe_asm
    import sfa_pkg::*;
#(
    parameter int SMP_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic             blk_start,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    input  logic [3:0]       left_aux,
    input  logic [3:0]       right_aux,
    input  logic             left_v,
    input  logic             right_v,
    input  logic             left_u,
    input  logic             right_u,
    input  logic             left_c,
    input  logic             right_c,
    output logic             sf_valid,
    output logic [31:0]      sf_word,
    output logic [1:0]       sf_kind,
    output logic             sf_chan_b
);
    localparam int N_CH = 2;

    chan_fields_t        live_l, live_r, held_r;
    chan_fields_t        pk_in [N_CH];
    logic [SLOT_CNT-1:0] pk_out [N_CH];
    logic                load_a, load_b, blk_now;

    always_comb begin
        live_l = '{aux: left_aux,  smp: SMP_MAX_W'(left_smp),
                   v: left_v,  u: left_u,  c: left_c};
        live_r = '{aux: right_aux, smp: SMP_MAX_W'(right_smp),
                   v: right_v, u: right_u, c: right_c};
    end

    assign pk_in[0] = live_l;
    assign pk_in[1] = held_r;

    sfa_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_stb  (frame_stb),
        .blk_start  (blk_start),
        .right_in   (live_r),
        .load_a     (load_a),
        .load_b     (load_b),
        .blk_now    (blk_now),
        .right_held (held_r)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_pack
        sfa_word_pack #(.SMP_W(SMP_W)) u_pack (
            .fields (pk_in[ch]),
            .word   (pk_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sf_valid  <= 1'b0;
            sf_word   <= '0;
            sf_kind   <= KIND_IDLE;
            sf_chan_b <= 1'b0;
        end else if (load_b) begin
            sf_valid  <= 1'b1;
            sf_word   <= pk_out[1];
            sf_kind   <= KIND_B;
            sf_chan_b <= 1'b1;
        end else if (load_a) begin
            sf_valid  <= 1'b1;
            sf_word   <= pk_out[0];
            sf_kind   <= blk_now ? KIND_BLK : KIND_A;
            sf_chan_b <= 1'b0;
        end else begin
            sf_valid  <= 1'b0;
            sf_word   <= '0;
            sf_kind   <= KIND_IDLE;
            sf_chan_b <= 1'b0;
        end
    end

    // R7
    parity_even_chk: assert property (@(posedge clk) disable iff (rst)
        sf_valid |-> (^sf_word[31:4]) == 1'b0);

    // R3
    preamble_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sf_valid |-> sf_word[3:0] == 4'h0);

    // R2
    a_then_b_chk: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && !sf_chan_b) |=> (sf_valid && sf_chan_b));

    // R9
    b_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && sf_chan_b) |-> sf_kind == KIND_B);

    // R9
    idle_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !sf_valid |-> (sf_kind == KIND_IDLE && !sf_chan_b));

    // R11
    strobe_take_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !(sf_valid && !sf_chan_b)) |=> (sf_valid && !sf_chan_b));

    // R10
    no_double_b_chk: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && sf_chan_b && !$past(frame_stb)) |=> !(sf_valid && sf_chan_b));

endmodule

// File: tb/tb_sfa_subframe_asm.sv
`timescale 1ns/1ps
module tb_sfa_subframe_asm;
    localparam int SW = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 1'b0, blk_start = 1'b0;
    logic [SW-1:0] left_smp = '0, right_smp = '0;
    logic [3:0] left_aux = '0, right_aux = '0;
    logic left_v = 0, right_v = 0, left_u = 0, right_u = 0, left_c = 0, right_c = 0;
    logic sf_valid, sf_chan_b;
    logic [31:0] sf_word;
    logic [1:0] sf_kind;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sfa_subframe_asm #(.SMP_W(SW)) dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .blk_start(blk_start),
        .left_smp(left_smp), .right_smp(right_smp),
        .left_aux(left_aux), .right_aux(right_aux),
        .left_v(left_v), .right_v(right_v), .left_u(left_u), .right_u(right_u),
        .left_c(left_c), .right_c(right_c),
        .sf_valid(sf_valid), .sf_word(sf_word), .sf_kind(sf_kind), .sf_chan_b(sf_chan_b)
    );

    function automatic logic [31:0] expw(input logic [3:0] a, input logic [SW-1:0] s,
                                         input logic [2:0] vuc);
        logic [31:0] w;
        w = (32'(a) << 4) | (32'(s) << (28 - SW)) | (32'(vuc) << 28);
        w[31] = ($countones(w[30:4]) % 2) == 1;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [31:0] w, input logic [1:0] k,
                           input logic v, input logic b);
        chk({req, " valid"}, 32'(sf_valid), 32'(v));
        chk({req, " word"},  sf_word, w);
        chk({req, " kind"},  32'(sf_kind), 32'(k));
        chk({req, " chan"},  32'(sf_chan_b), 32'(b));
    endtask

    task automatic load(input logic blk, input logic [3:0] la, ra,
                        input logic [SW-1:0] ls, rs, input logic [2:0] lf, rf);
        frame_stb = 1'b1; blk_start = blk;
        left_aux = la; right_aux = ra; left_smp = ls; right_smp = rs;
        {left_c, left_u, left_v} = lf; {right_c, right_u, right_v} = rf;
    endtask

    task automatic scramble();
        right_aux = ~right_aux; right_smp = ~right_smp;
        {right_c, right_u, right_v} = ~{right_c, right_u, right_v};
        left_aux = ~left_aux; blk_start = ~blk_start;
    endtask

    task automatic one_frame(input logic blk, input logic [3:0] la, ra,
                             input logic [SW-1:0] ls, rs, input logic [2:0] lf, rf);
        load(blk, la, ra, ls, rs, lf, rf);
        @(negedge clk);
        frame_stb = 1'b0;
        // R2 R4 R5 R6 R7 R9: A word from left
        chk_out("R4/R6/R9 A", expw(la, ls, lf), blk ? 2'b11 : 2'b01, 1'b1, 1'b0);
        scramble();
        @(negedge clk);
        // R8: B word from captured right
        chk_out("R8 B", expw(ra, rs, rf), 2'b10, 1'b1, 1'b1);
        @(negedge clk);
        // R2: idle afterwards
        chk_out("R2 idle", 32'h0, 2'b00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: in reset
        chk_out("R1 reset", 32'h0, 2'b00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R1 after", 32'h0, 2'b00, 1'b0, 1'b0);

        // R4 R6 R7 R9: every aux value with every V/U/C combination
        for (int a = 0; a < 16; a++) begin
            for (int f = 0; f < 8; f++) begin
                one_frame(f == 0, 4'(a), 4'(15 - a),
                          SW'(a * 7919 + f * 131), SW'(~(a * 7919 + f * 131)),
                          3'(f), 3'(7 - f));
            end
        end

        // R5: walking one through each sample slot
        for (int i = 0; i < SW; i++) begin
            one_frame(1'b0, 4'h0, 4'h0, SW'(1) << i, SW'(1) << (SW - 1 - i), 3'b0, 3'b0);
        end

        // R10: strobe during A cycle ignored
        load(1'b1, 4'h5, 4'hA, SW'(20'h12345), SW'(20'h6789A), 3'b101, 3'b010);
        @(negedge clk);
        chk_out("R10 A", expw(4'h5, SW'(20'h12345), 3'b101), 2'b11, 1'b1, 1'b0);
        load(1'b0, 4'h3, 4'hC, SW'(20'hFFFFF), SW'(20'h00001), 3'b111, 3'b111);
        @(negedge clk);
        frame_stb = 1'b0;
        chk_out("R10 B", expw(4'hA, SW'(20'h6789A), 3'b010), 2'b10, 1'b1, 1'b1);
        @(negedge clk);
        chk_out("R10 idle", 32'h0, 2'b00, 1'b0, 1'b0);

        // R11: back-to-back frames
        load(1'b0, 4'h1, 4'h2, SW'(20'hAAAAA), SW'(20'h55555), 3'b001, 3'b100);
        @(negedge clk);
        frame_stb = 1'b0;
        chk_out("R11 A1", expw(4'h1, SW'(20'hAAAAA), 3'b001), 2'b01, 1'b1, 1'b0);
        @(negedge clk);
        chk_out("R11 B1", expw(4'h2, SW'(20'h55555), 3'b100), 2'b10, 1'b1, 1'b1);
        load(1'b1, 4'h9, 4'h6, SW'(20'h0F0F0), SW'(20'hF0F0F), 3'b110, 3'b011);
        @(negedge clk);
        frame_stb = 1'b0;
        chk_out("R11 A2", expw(4'h9, SW'(20'h0F0F0), 3'b110), 2'b11, 1'b1, 1'b0);
        scramble();
        @(negedge clk);
        chk_out("R11 B2", expw(4'h6, SW'(20'hF0F0F), 3'b011), 2'b10, 1'b1, 1'b1);
        @(negedge clk);
        chk_out("R11 idle", 32'h0, 2'b00, 1'b0, 1'b0);

        // R1: reset mid-stream clears outputs
        load(1'b0, 4'hF, 4'hF, '1, '1, 3'b111, 3'b111);
        @(negedge clk);
        frame_stb = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk_out("R1 mid reset", 32'h0, 2'b00, 1'b0, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule